// File: doc/BRIEF.md
# Per-Field Calendar Alarm Comparator

This block watches a running BCD calendar (seconds, minutes, hours, weekday, day of month, month) and raises an alarm when the calendar reaches a programmed target. Each of the six target registers carries its own compare-enable bit. Software can therefore arm any subset of fields, for example "every hour at minute 15, second 30", and fields left disabled match any calendar value.

The calendar counter sits outside the block. It presents its six fields on `cal_i` together with a one-cycle `sec_tick_i` strobe that marks the cycle in which the fields have just been updated. The comparison is made only in a strobe cycle. A hit sets a sticky alarm flag, and the flag drives `irq_o` while the interrupt enable is set. Software reads and writes the target registers and a control register through a simple word-addressed port with a combinational read path. The expected software sequence is: clear the flag and the interrupt enable, reprogram the targets, then enable the interrupt again.

Top module: `alarm_comparator`

## Requirements
- R1: After reset every target register and the control register read as 0x00, and `irq_o` is 0.
- R2: Target registers for seconds, minutes, hours, weekday, day and month sit at word addresses 8, 9, 10, 11, 12 and 13. Bit 7 is the compare enable, bits 6:0 are the BCD target, and all eight bits read back as written.
- R3: The control register sits at address 14. Bit 3 is the alarm interrupt enable (read/write) and bit 0 is the alarm flag. Every other bit reads 0.
- R4: The flag is set on the clock edge that ends a cycle with `sec_tick_i` high, provided the comparison matches. Without a strobe, calendar values that would match never set it.
- R5: A field whose enable bit (bit 7) is 0 takes no part in the comparison. A mismatching calendar value in that field does not block the alarm.
- R6: With no field enabled, a strobe never sets the flag.
- R7: If any enabled field differs from its calendar field, the strobe does not set the flag.
- R8: The flag stays set until software writes 0 to control bit 0. Writing 1 to bit 0 while the flag is clear leaves it clear.
- R9: `irq_o` is high exactly when the flag and the interrupt enable are both set.
- R10: When a matching strobe and a software write clearing the flag fall in the same cycle, the flag ends up set.
- R11: Addresses 0 to 7 and 15 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle strobe: calendar fields just updated |
| cal_i | input | 42 | Calendar in BCD, 7 bits per field; bits 6:0 seconds, 13:7 minutes, 20:14 hours, 27:21 weekday, 34:28 day, 41:35 month |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench presents matching calendar values without a strobe. A design that compared continuously would set the flag early. It arms no fields at all, which catches a design that treats an empty enable mask as a vacuous match. It also arms partial subsets with a disabled field holding a mismatching value, which catches a design that compares disabled fields. It writes 1 to a clear flag, which a naive register would store. It puts a clearing write in the same cycle as a matching strobe, where a design that gave software priority would lose the alarm. The checks sample one cycle after the strobe, so a design that added or dropped a pipeline stage also fails.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS  = 6;
  localparam int FIELD_W     = 7;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int ALARM_BASE  = 8;
  localparam int CTRL_ADDR   = 14;
  localparam int FLAG_BIT    = 0;
  localparam int IE_BIT      = 3;
  localparam int EN_BIT      = 7;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int FIELD_W = 7,
  parameter int DATA_W  = 8,
  parameter int EN_BIT  = 7
) (
  input  logic [DATA_W-1:0]  target_i,
  input  logic [FIELD_W-1:0] cal_i,
  output logic               en_o,
  output logic               hit_o
);
  assign en_o  = target_i[EN_BIT];
  // disabled field is a don't-care
  assign hit_o = !en_o || (target_i[FIELD_W-1:0] == cal_i);
endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int NUM_FIELDS = 6,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int ALARM_BASE = 8,
  parameter int CTRL_ADDR  = 14,
  parameter int FLAG_BIT   = 0,
  parameter int IE_BIT     = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             flag_i,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] target_o,
  output logic                             ie_o,
  output logic                             ctrl_we_o,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] target_q;
  logic                              ie_q;

  assign ctrl_we_o = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_target
    localparam logic [ADDR_W-1:0] MyAddr = ADDR_W'(ALARM_BASE + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       target_q[k] <= '0;
      else if (we_i && addr_i == MyAddr) target_q[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ie_q <= 1'b0;
    else if (ctrl_we_o) ie_q <= wdata_i[IE_BIT];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_FIELDS; k++)
      if (addr_i == ADDR_W'(ALARM_BASE + k)) rdata_o = target_q[k];
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rdata_o[FLAG_BIT] = flag_i;
      rdata_o[IE_BIT]   = ie_q;
    end
  end

  assign target_o = target_q;
  assign ie_o     = ie_q;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              match_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ie_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic flag_q;

  // hardware set wins over a same-cycle software clear; writing 1 is a no-op
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_q <= 1'b0;
    else if (tick_i && match_i)               flag_q <= 1'b1;
    else if (ctrl_we_i && !wdata_i[FLAG_BIT]) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
  import alarm_cmp_pkg::*;
#(
  parameter int N_FIELDS = NUM_FIELDS,
  parameter int FW       = FIELD_W,
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  localparam int CAL_W   = N_FIELDS * FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_tick_i,
  input  logic [CAL_W-1:0] cal_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic [N_FIELDS-1:0][DW-1:0] target;
  logic [N_FIELDS-1:0]         en_mask;
  logic [N_FIELDS-1:0]         hit;
  logic                        match;
  logic                        flag_q;
  logic                        ie_q;
  logic                        ctrl_we;

  alarm_regfile #(
    .NUM_FIELDS(N_FIELDS), .DATA_W(DW), .ADDR_W(AW), .ALARM_BASE(ALARM_BASE),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)
  ) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .flag_i   (flag_q),
    .target_o (target),
    .ie_o     (ie_q),
    .ctrl_we_o(ctrl_we),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_cmp
    alarm_field_cmp #(.FIELD_W(FW), .DATA_W(DW), .EN_BIT(EN_BIT)) i_cmp (
      .target_i(target[k]),
      .cal_i   (cal_i[k*FW +: FW]),
      .en_o    (en_mask[k]),
      .hit_o   (hit[k])
    );
  end

  // at least one armed field, and every field agrees
  assign match = (|en_mask) && (&hit);

  alarm_flag_ctrl #(.DATA_W(DW), .FLAG_BIT(FLAG_BIT)) i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (sec_tick_i),
    .match_i  (match),
    .ctrl_we_i(ctrl_we),
    .wdata_i  (reg_wdata_i),
    .ie_i     (ie_q),
    .flag_o   (flag_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/alarm_cmp_checker.sv
module alarm_cmp_checker
  import alarm_cmp_pkg::*;
#(
  parameter int N_FIELDS = NUM_FIELDS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sec_tick_i,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic                irq_o,
  input logic                flag_q,
  input logic                ie_q,
  input logic                match,
  input logic [N_FIELDS-1:0] en_mask
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));

  assert_flag_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(sec_tick_i));

  assert_empty_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && en_mask == '0 && !flag_q) |=> !flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ctrl_wr) |=> flag_q);

  assert_no_irq_when_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);

  assert_irq_rise_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($rose(flag_q) || $rose(ie_q)));

  assert_set_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && match && ctrl_wr) |=> flag_q);
endmodule

bind alarm_comparator alarm_cmp_checker #(.N_FIELDS(N_FIELDS)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sec_tick_i (sec_tick_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .flag_q     (flag_q),
  .ie_q       (ie_q),
  .match      (match),
  .en_mask    (en_mask)
);

// File: tb/test_alarm_comparator.sv
module test_alarm_comparator;
  localparam int CLK_PERIOD = 10;
  localparam int CAL_W = 42;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [CAL_W-1:0] cal = '0;
  logic             we = 1'b0;
  logic [3:0]       addr = '0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic             irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_comparator i_alarm_comparator (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .cal_i(cal),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [CAL_W-1:0] mk(input logic [6:0] s, mi, h, wd, d, mo);
    return {mo, d, wd, h, mi, s};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_tick(input logic [CAL_W-1:0] c);
    @(negedge clk); cal = c; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic check_ctrl(input string req, input logic [7:0] exp, input logic exp_irq);
    logic [7:0] v;
    rd(4'd14, v);
    check(req, v, exp);
    check({req, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 8; a <= 14; a++) begin
      rd(4'(a), v);
      check("R1 reset reg", v, 8'h00);
    end
    check("R1 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    for (int k = 0; k < 6; k++) wr(4'(8 + k), 8'h80 | 8'(k * 17 + 3));
    for (int k = 0; k < 6; k++) begin
      rd(4'(8 + k), v);
      check("R2 target readback", v, 8'h80 | 8'(k * 17 + 3));
    end
  endtask

  task automatic t_ctrl_and_unmapped;
    logic [7:0] v;
    wr(4'd14, 8'hFF);                 // flag write 1 while clear: no effect
    check_ctrl("R3 R8 ctrl write 0xFF", 8'h08, 1'b0);
    wr(4'd14, 8'h00);
    check_ctrl("R3 ctrl clear", 8'h00, 1'b0);
    wr(4'd3, 8'hAA);
    wr(4'd15, 8'h55);
    rd(4'd3, v);  check("R11 unmapped read 3", v, 8'h00);
    rd(4'd15, v); check("R11 unmapped read 15", v, 8'h00);
    rd(4'd0, v);  check("R11 unmapped read 0", v, 8'h00);
    rd(4'd8, v);  check("R11 target untouched", v, 8'h83);
  endtask

  task automatic t_partial_match;
    // arm seconds=0x30 and minutes=0x15 only
    for (int k = 0; k < 6; k++) wr(4'(8 + k), 8'h00);
    wr(4'd8, 8'hB0);
    wr(4'd9, 8'h95);
    wr(4'd14, 8'h08);
    @(negedge clk); cal = mk(7'h30, 7'h15, 7'h07, 7'h02, 7'h19, 7'h04);
    repeat (3) @(negedge clk);
    check_ctrl("R4 no tick no flag", 8'h08, 1'b0);
    do_tick(mk(7'h30, 7'h15, 7'h23, 7'h05, 7'h31, 7'h11));
    #1 check("R4 R5 flag next cycle irq", {7'd0, irq}, 8'h01);
    check_ctrl("R5 partial match", 8'h09, 1'b1);
  endtask

  task automatic t_sticky;
    do_tick(mk(7'h31, 7'h15, 7'h07, 7'h02, 7'h19, 7'h04));
    repeat (2) @(negedge clk);
    check_ctrl("R8 sticky", 8'h09, 1'b1);
    wr(4'd14, 8'h08);
    check_ctrl("R8 clear by 0", 8'h08, 1'b0);
  endtask

  task automatic t_mismatch;
    do_tick(mk(7'h30, 7'h16, 7'h07, 7'h02, 7'h19, 7'h04));
    check_ctrl("R7 minute mismatch", 8'h08, 1'b0);
  endtask

  task automatic t_irq_gate;
    wr(4'd14, 8'h00);
    do_tick(mk(7'h30, 7'h15, 7'h00, 7'h00, 7'h01, 7'h01));
    check_ctrl("R9 flag without ie", 8'h01, 1'b0);
    wr(4'd14, 8'h09);
    check_ctrl("R9 ie raises irq", 8'h09, 1'b1);
    wr(4'd14, 8'h00);
    check_ctrl("R9 clear both", 8'h00, 1'b0);
  endtask

  task automatic t_empty_mask;
    wr(4'd8, 8'h30);
    wr(4'd9, 8'h15);
    wr(4'd14, 8'h08);
    do_tick(mk(7'h30, 7'h15, 7'h00, 7'h00, 7'h00, 7'h00));
    check_ctrl("R6 no field armed", 8'h08, 1'b0);
  endtask

  task automatic t_set_beats_clear;
    wr(4'd8, 8'hB0);
    @(negedge clk);
    cal = mk(7'h30, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
    tick = 1'b1; we = 1'b1; addr = 4'd14; wdata = 8'h08;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    check_ctrl("R10 set wins", 8'h09, 1'b1);
    wr(4'd14, 8'h08);
  endtask

  task automatic t_all_fields;
    wr(4'd8, 8'hD9); wr(4'd9, 8'hD9); wr(4'd10, 8'hA3);
    wr(4'd11, 8'h86); wr(4'd12, 8'hB1); wr(4'd13, 8'h92);
    do_tick(mk(7'h59, 7'h59, 7'h23, 7'h05, 7'h31, 7'h12));
    check_ctrl("R7 weekday mismatch", 8'h08, 1'b0);
    do_tick(mk(7'h59, 7'h59, 7'h23, 7'h06, 7'h31, 7'h12));
    check_ctrl("R4 all six fields", 8'h09, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_ctrl_and_unmapped();
    t_partial_match();
    t_sticky();
    t_mismatch();
    t_irq_gate();
    t_empty_mask();
    t_set_beats_clear();
    t_all_fields();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule